// File: doc/BRIEF.md
# Two-Wire Word-Buffered Memory Slave

This block is the slave side of a two-wire serial link that gives a host controller access to a small non-volatile word array. The array has 32 rows of 16 bits and is modelled here as flip-flops. A free-running system clock samples the clock and data lines, so it must run several times faster than the serial clock. Every transfer begins with START and one control byte. That byte carries the row number, a two-bit mode field and the direction bit. The addressed row is then copied into a 16-bit word buffer, and every later byte moves through that buffer.

A write replaces one or both halves of the buffer. On STOP the buffer is programmed back into the row. A programming period, counted in system clock cycles, follows. During it the slave refuses every control byte, so the host can poll for completion. A read streams bytes out of the buffer. After both halves of a row have gone out, the slave moves to the next or previous row, with wrap-around, until the host answers with NACK. Control bytes that end in three ones are not memory accesses. They are acknowledged, reported on a side port for other blocks, and shut off memory access until STOP.

Top module: `twm_word_slave`

## Requirements
- R1: A control byte holds the row in bits [7:3], the mode in bits [2:1] and the direction in bit 0 (0 = write, 1 = read). It is acknowledged only when no programming is in progress and the mode is 01 or 10. Mode 00 and the reserved pattern 110 in bits [2:0] are refused with NACK.
- R2: On acceptance of a control byte the whole addressed row is loaded into the buffer. A write of a single byte therefore leaves the other half of the row unchanged.
- R3: Mode 01 handles the low byte (bits 7:0) first and the high byte second. Mode 10 handles the high byte first. The rule applies to both writes and reads.
- R4: A STOP after one or two acknowledged data bytes programs the buffer into the row. A STOP directly after the control byte programs nothing and starts no busy period. A START before STOP abandons the write. A third data byte is refused with NACK, but the first two are still programmed.
- R5: Programming raises busy_o for PROG_CYCLES clock cycles. Every control byte that arrives in that time is refused, and the array is never written while busy_o is high.
- R6: During a read, after the second byte of a row has been acknowledged, the next row is loaded: row+1 in mode 01 and row-1 in mode 10. Row 31 wraps to 0 and row 0 wraps to 31.
- R7: After a NACK from the master on a read byte, the slave releases SDA and ignores all further clock pulses until START or STOP.
- R8: A fall of SDA while SCL is high is START. It restarts control-byte reception from any state. A rise of SDA while SCL is high is STOP. The slave changes its SDA drive only while SCL is low.
- R9: A control byte with bits [2:0] = 111 is acknowledged. It produces a one-cycle spec_valid_o pulse with the byte on spec_code_o and holds spec_active_o high until the next START or STOP. Data bytes that follow it are refused and leave the array unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus (wired-AND of all drivers) |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| busy_o | output | 1 | High while a row is being programmed |
| spec_valid_o | output | 1 | One-cycle pulse when a special control byte is accepted |
| spec_code_o | output | 8 | The accepted special control byte |
| spec_active_o | output | 1 | High from acceptance of a special byte until the next START or STOP |

## Verification
The assertions assume that the master keeps each SCL phase longer than the synchronizer delay and moves SDA only while SCL is low, except when it forms START or STOP. They also assume that the master never forms START or STOP while the slave holds SDA low. The bench's master tasks hold each quarter bit for five clock cycles, well beyond the three-cycle sampling delay. Its repeated START follows a write acknowledge, when the slave has released the line, and its STOPs follow either a write acknowledge or a master NACK.

// File: rtl/twm_pkg.sv
package twm_pkg;

   typedef enum logic [2:0] {
      S_IDLE,   // standby, waiting for START
      S_CBIT,   // shifting in the control byte
      S_CACK,   // acknowledge slot of the control byte
      S_WBIT,   // shifting in a write data byte
      S_WACK,   // acknowledge slot of a write data byte
      S_RBIT,   // shifting out a read byte
      S_RACK,   // master acknowledge slot after a read byte
      S_WAIT    // ignoring the bus until START or STOP
   } twm_state_e;

   localparam logic [1:0] MODE_LO_FIRST = 2'b01;
   localparam logic [1:0] MODE_HI_FIRST = 2'b10;
   localparam logic [2:0] SPECIAL_TAG   = 3'b111;

   function automatic logic [7:0] twm_half(input logic [15:0] w, input logic hi);
      return hi ? w[15:8] : w[7:0];
   endfunction

endpackage

// File: rtl/twm_line_sync.sv
module twm_line_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_p,
   output logic stop_p
);

   initial assert (SYNC_STAGES >= 0 && SYNC_STAGES <= 4)
      else $error("twm_line_sync: SYNC_STAGES out of range");

   generate
      if (SYNC_STAGES == 0) begin : g_bypass
         assign scl_s = scl_i;
         assign sda_s = sda_i;
      end else begin : g_chain
         logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_ff <= '1;
               sda_ff <= '1;
            end else begin
               scl_ff[0] <= scl_i;
               sda_ff[0] <= sda_i;
               for (int i = 1; i < SYNC_STAGES; i++) begin
                  scl_ff[i] <= scl_ff[i-1];
                  sda_ff[i] <= sda_ff[i-1];
               end
            end
         end
         assign scl_s = scl_ff[SYNC_STAGES-1];
         assign sda_s = sda_ff[SYNC_STAGES-1];
      end
   endgenerate

   logic scl_p, sda_p;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_s;
         sda_p <= sda_s;
      end
   end

   assign scl_rise = scl_s & ~scl_p;
   assign scl_fall = ~scl_s & scl_p;
   assign start_p  = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_p   = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/twm_row_store.sv
module twm_row_store #(
   parameter int ADDR_W      = 5,
   parameter int WORD_W      = 16,
   parameter int PROG_CYCLES = 2000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [WORD_W-1:0] rd_data,
   input  logic              we,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   output logic              busy
);

   localparam int ROWS = 1 << ADDR_W;
   localparam int CW   = $clog2(PROG_CYCLES + 1);

   initial assert (PROG_CYCLES > 0)
      else $error("twm_row_store: PROG_CYCLES must be positive");

   logic [WORD_W-1:0] mem [ROWS];
   logic [CW-1:0]     cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < ROWS; r++) mem[r] <= '0;
         cnt <= '0;
      end else if (we) begin
         mem[wr_addr] <= wr_data;
         cnt          <= CW'(PROG_CYCLES);
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign rd_data = mem[rd_addr];
   assign busy    = (cnt != '0);

   // R5
   prog_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> !busy);
   // R5
   busy_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(we));

endmodule

// File: rtl/twm_word_slave.sv
module twm_word_slave
   import twm_pkg::*;
#(
   parameter int ADDR_W      = 5,
   parameter int WORD_W      = 16,
   parameter int PROG_CYCLES = 2000,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_oe_o,
   output logic       busy_o,
   output logic       spec_valid_o,
   output logic [7:0] spec_code_o,
   output logic       spec_active_o
);

   initial assert (WORD_W == 16)
      else $error("twm_word_slave: the buffer holds exactly two bytes");
   initial assert (ADDR_W >= 1 && ADDR_W <= 5)
      else $error("twm_word_slave: row field of the control byte is five bits");

   logic scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;

   twm_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_p(start_p), .stop_p(stop_p)
   );

   twm_state_e        state;
   logic [3:0]        bitcnt;
   logic [7:0]        shreg, txsh;
   logic [ADDR_W-1:0] addr, addr_step, rd_addr;
   logic [WORD_W-1:0] wbuf, rd_data;
   logic              lo_first, is_read, is_spec, ack_q, mack, byte_idx, pending;
   logic [1:0]        wr_cnt;
   logic              busy, ctrl_ok, mem_we;

   assign addr_step = lo_first ? addr + ADDR_W'(1) : addr - ADDR_W'(1);
   assign rd_addr   = (state == S_CBIT) ? shreg[3 +: ADDR_W] : addr_step;
   assign mem_we    = stop_p & pending;
   assign ctrl_ok   = !busy && (shreg[2:0] == SPECIAL_TAG ||
                                shreg[2:1] == MODE_LO_FIRST ||
                                shreg[2:1] == MODE_HI_FIRST);

   twm_row_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .PROG_CYCLES(PROG_CYCLES)) u_store (
      .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
      .we(mem_we), .wr_addr(addr), .wr_data(wbuf), .busy(busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state         <= S_IDLE;
         bitcnt        <= '0;
         shreg         <= '0;
         txsh          <= '0;
         addr          <= '0;
         wbuf          <= '0;
         lo_first      <= 1'b0;
         is_read       <= 1'b0;
         is_spec       <= 1'b0;
         ack_q         <= 1'b0;
         mack          <= 1'b1;
         byte_idx      <= 1'b0;
         pending       <= 1'b0;
         wr_cnt        <= '0;
         spec_valid_o  <= 1'b0;
         spec_code_o   <= '0;
         spec_active_o <= 1'b0;
      end else begin
         spec_valid_o <= 1'b0;
         if (start_p) begin
            state         <= S_CBIT;
            bitcnt        <= '0;
            pending       <= 1'b0;
            wr_cnt        <= '0;
            spec_active_o <= 1'b0;
         end else if (stop_p) begin
            state         <= S_IDLE;
            pending       <= 1'b0;
            wr_cnt        <= '0;
            spec_active_o <= 1'b0;
         end else if (scl_rise) begin
            case (state)
               S_CBIT, S_WBIT: begin
                  shreg  <= {shreg[6:0], sda_s};
                  bitcnt <= bitcnt + 4'd1;
               end
               S_RACK:  mack <= sda_s;
               default: ;
            endcase
         end else if (scl_fall) begin
            case (state)
               S_CBIT: if (bitcnt == 4'd8) begin
                  state    <= S_CACK;
                  ack_q    <= ctrl_ok;
                  addr     <= shreg[3 +: ADDR_W];
                  lo_first <= (shreg[2:1] == MODE_LO_FIRST);
                  is_read  <= shreg[0];
                  is_spec  <= (shreg[2:0] == SPECIAL_TAG);
                  wbuf     <= rd_data;
                  if (ctrl_ok && shreg[2:0] == SPECIAL_TAG) begin
                     spec_valid_o  <= 1'b1;
                     spec_code_o   <= shreg;
                     spec_active_o <= 1'b1;
                  end
               end
               S_CACK: begin
                  bitcnt <= '0;
                  if (!ack_q || is_spec) begin
                     state <= S_WAIT;
                  end else if (is_read) begin
                     state    <= S_RBIT;
                     byte_idx <= 1'b0;
                     txsh     <= twm_half(wbuf, ~lo_first);
                  end else begin
                     state <= S_WBIT;
                  end
               end
               S_WBIT: if (bitcnt == 4'd8) begin
                  state <= S_WACK;
                  if (wr_cnt < 2'd2) begin
                     ack_q   <= 1'b1;
                     pending <= 1'b1;
                     wr_cnt  <= wr_cnt + 2'd1;
                     if (wr_cnt[0] ^ ~lo_first) wbuf[15:8] <= shreg;
                     else                       wbuf[7:0]  <= shreg;
                  end else begin
                     ack_q <= 1'b0;
                  end
               end
               S_WACK: begin
                  bitcnt <= '0;
                  state  <= ack_q ? S_WBIT : S_WAIT;
               end
               S_RBIT: begin
                  if (bitcnt == 4'd7) begin
                     state <= S_RACK;
                  end else begin
                     txsh   <= {txsh[6:0], 1'b0};
                     bitcnt <= bitcnt + 4'd1;
                  end
               end
               S_RACK: begin
                  if (!mack) begin
                     state  <= S_RBIT;
                     bitcnt <= '0;
                     if (!byte_idx) begin
                        byte_idx <= 1'b1;
                        txsh     <= twm_half(wbuf, lo_first);
                     end else begin
                        byte_idx <= 1'b0;
                        addr     <= addr_step;
                        wbuf     <= rd_data;
                        txsh     <= twm_half(rd_data, ~lo_first);
                     end
                  end else begin
                     state <= S_WAIT;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      case (state)
         S_CACK, S_WACK: sda_oe_o = ack_q;
         S_RBIT:         sda_oe_o = ~txsh[7];
         default:        sda_oe_o = 1'b0;
      endcase
   end

   assign busy_o = busy;

   // R8
   sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe_o != $past(sda_oe_o)) |-> !scl_s);
   // R5
   busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_CACK && sda_oe_o) |-> !busy);
   // R9
   spec_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spec_valid_o |=> !spec_valid_o);
   // R4
   prog_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (wr_cnt != 2'd0));
   // R7
   release_after_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state) == S_RACK && state == S_WAIT) |-> !sda_oe_o);

endmodule

// File: tb/tb_twm_word_slave.sv
`timescale 1ns/1ps
module tb_twm_word_slave;

   localparam int AW   = 5;
   localparam int PROG = 300;
   localparam int Q    = 5;

   logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1;
   logic sda_oe, busy, spec_valid, spec_active;
   logic [7:0] spec_code;
   wire sda_bus = m_sda & ~sda_oe;

   always #2.5 clk = ~clk;

   twm_word_slave #(.ADDR_W(AW), .WORD_W(16), .PROG_CYCLES(PROG), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
      .sda_oe_o(sda_oe), .busy_o(busy), .spec_valid_o(spec_valid),
      .spec_code_o(spec_code), .spec_active_o(spec_active)
   );

   int n_chk = 0, n_bad = 0, spec_seen = 0;
   logic [7:0]  spec_last = 8'h00;
   logic [15:0] model [32];

   always @(posedge clk) if (spec_valid) begin
      spec_seen <= spec_seen + 1;
      spec_last <= spec_code;
   end

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog (all requirements): actual hung expected done");
      summary();
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_start;
      m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
      m_sda = 1'b0; tick(Q); m_scl = 1'b0; tick(Q);
   endtask

   task automatic do_stop;
      m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(Q); m_sda = 1'b1; tick(Q);
   endtask

   task automatic bit_io(input logic b, output logic r);
      m_sda = b; tick(Q); m_scl = 1'b1; tick(Q);
      r = sda_bus; tick(Q); m_scl = 1'b0; tick(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      logic r;
      for (int i = 7; i >= 0; i--) bit_io(b[i], r);
      bit_io(1'b1, r);
      ack = ~r;
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] d);
      logic r;
      for (int i = 7; i >= 0; i--) begin
         bit_io(1'b1, r);
         d[i] = r;
      end
      bit_io(~give_ack, r);
   endtask

   function automatic logic [7:0] ctl(input int row, input logic lo, input logic rd);
      return {5'(row), (lo ? 2'b01 : 2'b10), rd};
   endfunction

   function automatic logic [15:0] pattern(input int r);
      return 16'(r * 11213 + 17029);
   endfunction

   // START + control byte, repeated until acknowledged
   task automatic open_ctrl(input logic [7:0] c, output int tries);
      logic a;
      tries = 0;
      do begin
         do_start();
         send_byte(c, a);
         tries++;
         if (!a) do_stop();
      end while (!a && tries < 100);
   endtask

   task automatic wait_idle;
      int g = 0;
      while (busy && g < 20000) begin tick(1); g++; end
   endtask

   task automatic read_seq(input int row, input logic lo, input int n, input string req);
      int tries, r;
      logic idx;
      logic [7:0] d, e;
      open_ctrl(ctl(row, lo, 1'b1), tries);
      r = row; idx = 1'b0;
      for (int k = 0; k < n; k++) begin
         recv_byte(k < n - 1, d);
         e = (idx ^ ~lo) ? model[r][15:8] : model[r][7:0];
         check($sformatf("%s row %0d byte %0d", req, r, idx), {24'd0, d}, {24'd0, e});
         if (idx) r = lo ? (r + 1) % 32 : (r + 31) % 32;
         idx = ~idx;
      end
      do_stop();
   endtask

   initial begin
      int tries;
      logic a0, a1, a2;
      logic [7:0] d;
      logic any_low;
      int seen0;

      for (int r = 0; r < 32; r++) model[r] = 16'h0000;
      tick(10);
      rst_n = 1'b1;
      tick(4);
      check("R8 reset sda released", {31'd0, sda_oe}, 0);
      check("R5 reset not busy", {31'd0, busy}, 0);
      check("R9 reset no special", {30'd0, spec_valid, spec_active}, 0);

      // sweep: two-byte writes to every row, order alternating by row parity
      for (int r = 0; r < 32; r++) begin
         logic lo;
         logic [15:0] w;
         lo = (r % 2 == 0);
         w  = pattern(r);
         open_ctrl(ctl(r, lo, 1'b0), tries);
         if (r > 0) check("R5 control refused while programming", {31'd0, tries > 1}, 1);
         send_byte(lo ? w[7:0] : w[15:8], a0);
         send_byte(lo ? w[15:8] : w[7:0], a1);
         check("R3 write data acknowledged", {30'd0, a0, a1}, 3);
         do_stop();
         model[r] = w;
         check("R5 busy after program", {31'd0, busy}, 1);
      end
      wait_idle();

      read_seq(0, 1'b1, 64, "R6 increment read");
      read_seq(31, 1'b0, 64, "R6 decrement read");
      read_seq(30, 1'b1, 6, "R6 wrap up");
      read_seq(1, 1'b0, 8, "R6 wrap down");

      // R2: single-byte write, high first, keeps low half
      open_ctrl(ctl(5, 1'b0, 1'b0), tries);
      send_byte(8'h9C, a0);
      do_stop();
      model[5][15:8] = 8'h9C;
      wait_idle();
      read_seq(5, 1'b1, 2, "R2 one-byte write");

      // R4: control-only write programs nothing
      open_ctrl(ctl(6, 1'b1, 1'b0), tries);
      do_stop();
      tick(4);
      check("R4 no busy after control-only", {31'd0, busy}, 0);
      read_seq(6, 1'b1, 2, "R4 control-only row kept");

      // R4/R8: repeated START abandons the write
      open_ctrl(ctl(7, 1'b1, 1'b0), tries);
      send_byte(8'hEE, a0);
      do_start();
      send_byte(ctl(7, 1'b1, 1'b1), a1);
      check("R8 control after repeated START acked", {31'd0, a1}, 1);
      recv_byte(1'b1, d);
      check("R4 aborted write low byte", {24'd0, d}, {24'd0, model[7][7:0]});
      recv_byte(1'b0, d);
      check("R4 aborted write high byte", {24'd0, d}, {24'd0, model[7][15:8]});
      do_stop();
      check("R4 no busy after abort", {31'd0, busy}, 0);

      // R4: third data byte refused
      open_ctrl(ctl(8, 1'b1, 1'b0), tries);
      send_byte(8'h11, a0);
      send_byte(8'h22, a1);
      send_byte(8'h33, a2);
      check("R4 third byte nacked", {29'd0, a0, a1, a2}, 6);
      do_stop();
      model[8] = 16'h2211;
      wait_idle();
      read_seq(8, 1'b0, 2, "R4 two bytes kept");

      // R1: mode 00 and reserved 110 refused
      do_start();
      send_byte({5'd9, 3'b000}, a0);
      do_stop();
      check("R1 mode 00 nacked", {31'd0, a0}, 0);
      do_start();
      send_byte({5'd10, 3'b110}, a0);
      do_stop();
      check("R1 reserved 110 nacked", {31'd0, a0}, 0);

      // R9: special control byte
      seen0 = spec_seen;
      do_start();
      send_byte(8'h47, a0);
      check("R9 special acked", {31'd0, a0}, 1);
      check("R9 one pulse", spec_seen - seen0, 1);
      check("R9 code", {24'd0, spec_last}, 32'h47);
      check("R9 active", {31'd0, spec_active}, 1);
      send_byte(8'h55, a1);
      check("R9 data refused", {31'd0, a1}, 0);
      do_stop();
      check("R9 active cleared", {31'd0, spec_active}, 0);
      check("R9 no programming", {31'd0, busy}, 0);
      read_seq(8, 1'b1, 2, "R9 row untouched");

      // R7: after master NACK the slave stays off the line
      open_ctrl(ctl(3, 1'b1, 1'b1), tries);
      recv_byte(1'b0, d);
      check("R7 byte before NACK", {24'd0, d}, {24'd0, model[3][7:0]});
      any_low = 1'b0;
      for (int i = 0; i < 9; i++) begin
         logic r;
         bit_io(1'b1, r);
         if (!r) any_low = 1'b1;
      end
      check("R7 line released after NACK", {31'd0, any_low}, 0);
      do_stop();

      summary();
   end

endmodule